// File: doc/BRIEF.md
# Sixteen-bit ALU with condition flags

This block is the arithmetic and logic unit of a small load/store processor together with its four-bit condition flag register. Every cycle it combines two 16-bit operands under a 4-bit operation code and drives the result combinationally, with a strobe that says whether the result should be written back. From the same operation it also works out the next negative, zero, carry and overflow bits.

The flag register takes those bits on a clock edge only when the control unit raises `flag_we`. The control unit holds `flag_we` low for instructions that do not use the ALU. It also holds it low when the adder computes a stack-pointer address. In that case the sum still appears on `result_o` while the flags stay as they were. The registered flags feed the branch-condition logic.

The datapath is combinational, so the block has no sequencing states. Its only storage is the flag register, which has two transitions: *load* (`flag_we` high with a legal code) and *hold* (every other cycle). A synchronous reset forces it to zero.

Top module: `nzcv_alu`

## Requirements
- R1: Code 0 (add) drives a+b modulo 2^16 with `result_valid_o` high. C is set when the unsigned sum exceeds 16'hFFFF. V is set when both operands have the same sign and the result's sign differs from it.
- R2: Code 1 (subtract) drives a−b modulo 2^16 with `result_valid_o` high. C is the inverse of borrow, so it is set when a ≥ b unsigned. V is set when the operands' signs differ and the result's sign differs from a's.
- R3: Code 6 (compare) updates the flags exactly as subtract does and drives a−b on `result_o`, with `result_valid_o` low.
- R4: Codes 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT a) drive the bitwise result with `result_valid_o` high. When the flags are loaded, V is cleared and C keeps its old value.
- R5: On every flag load, N (`flags_o[3]`) takes bit 15 of the result, and Z (`flags_o[2]`) is set exactly when all 16 result bits are zero.
- R6: Codes 7 (logical left), 8 (logical right) and 9 (arithmetic right) shift a by b[3:0] places with `result_valid_o` high. For a nonzero amount, C (`flags_o[1]`) takes the last bit shifted out and V (`flags_o[0]`) is cleared.
- R7: A shift by zero places drives a unchanged, leaves C unchanged and clears V.
- R8: While `flag_we` is low, all four flags stay unchanged and `result_o` and `result_valid_o` still follow the operation.
- R9: While `rst` is high at a clock edge, the flags become 4'b0000.
- R10: Codes 10 to 15 drive a zero result with `result_valid_o` low and never change the flags, even with `flag_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand, and the value that is shifted |
| b_i | input | 16 | Second operand; bits 3:0 give the shift amount |
| flag_we | input | 1 | Loads the flags at the next edge |
| result_o | output | 16 | Combinational result |
| result_valid_o | output | 1 | The result is meant for write-back |
| flags_o | output | 4 | Registered {N, Z, C, V} |

## Verification
Two functions can fall in the same cycle: a new result computed from the operands, and the flag register either holding or loading state that the previous cycle produced. The bench provokes this with stack-pointer style adds and subtracts under `flag_we` low, placed between flag-setting operations. It also uses logic and zero-length shifts whose new C must come from the old flags. A behavioural reference model predicts each cycle's result from the operands and the flags from its own copy of the last loaded state. Both are compared every clock, so a hold that leaks or a carry taken from the wrong cycle shows up at once.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_NOT = 4'd5,
        OP_CMP = 4'd6,
        OP_LSL = 4'd7,
        OP_LSR = 4'd8,
        OP_ASR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int W = 16
) (
    input  alu16_pkg::alu_op_e op_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    output logic [W-1:0]       res_o
);
    import alu16_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  alu16_pkg::alu_op_e op_i,
    input  logic [W-1:0]       a_i,
    input  logic [AW-1:0]      amt_i,
    output logic [W-1:0]       res_o,
    output logic               carry_o,
    output logic               moved_o
);
    import alu16_pkg::*;

    logic [W:0]        left_ext;
    logic [W:0]        right_ext;
    logic signed [W:0] arith_ext;

    always_comb begin
        left_ext  = {1'b0, a_i} << amt_i;
        right_ext = {a_i, 1'b0} >> amt_i;
        arith_ext = $signed({a_i, 1'b0}) >>> amt_i;
        moved_o   = (amt_i != '0);
        unique case (op_i)
            OP_LSL: begin
                res_o   = left_ext[W-1:0];
                carry_o = left_ext[W];
            end
            OP_LSR: begin
                res_o   = right_ext[W:1];
                carry_o = right_ext[0];
            end
            OP_ASR: begin
                res_o   = arith_ext[W:1];
                carry_o = arith_ext[0];
            end
            default: begin
                res_o   = '0;
                carry_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         flag_we,
    output logic [W-1:0] result_o,
    output logic         result_valid_o,
    output logic [3:0]   flags_o
);
    import alu16_pkg::*;

    localparam int AW = $clog2(W);

    alu_op_e      op;
    flags_t       flags_q;
    flags_t       flags_d;
    logic         op_legal;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_v;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic         sh_moved;

    assign op = alu_op_e'(op_i);

    alu16_addsub #(.W(W)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (op != OP_ADD),
        .sum_o  (as_sum),
        .carry_o(as_c),
        .ovf_o  (as_v)
    );

    alu16_logic #(.W(W)) u_logic (
        .op_i (op),
        .a_i  (a_i),
        .b_i  (b_i),
        .res_o(lg_res)
    );

    alu16_shift #(.W(W), .AW(AW)) u_shift (
        .op_i   (op),
        .a_i    (a_i),
        .amt_i  (b_i[AW-1:0]),
        .res_o  (sh_res),
        .carry_o(sh_c),
        .moved_o(sh_moved)
    );

    // Result selection and next-flag computation
    always_comb begin
        flags_d        = flags_q;
        op_legal       = 1'b1;
        result_valid_o = 1'b1;
        result_o       = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result_o  = as_sum;
                flags_d.c = as_c;
                flags_d.v = as_v;
            end
            OP_CMP: begin
                result_o       = as_sum;
                result_valid_o = 1'b0;
                flags_d.c      = as_c;
                flags_d.v      = as_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                result_o  = lg_res;
                flags_d.v = 1'b0;
            end
            OP_LSL, OP_LSR, OP_ASR: begin
                result_o  = sh_res;
                flags_d.v = 1'b0;
                if (sh_moved) flags_d.c = sh_c;
            end
            default: begin
                op_legal       = 1'b0;
                result_valid_o = 1'b0;
            end
        endcase
        flags_d.n = result_o[W-1];
        flags_d.z = (result_o == '0);
    end

    // Flag register: load or hold
    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (flag_we && op_legal)
            flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // Assertions
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            p_reset_clear_r9: assert (flags_o == 4'b0000)
                else $error("flags not cleared by reset");
        end
    end

    p_hold_flags_r8: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_o));

    p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_legal |=> $stable(flags_o));

    p_cmp_no_wb_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd6) |-> !result_valid_o);

    p_n_track_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_legal) |=> flags_o[3] == $past(result_o[W-1]));

    p_z_track_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_legal) |=> flags_o[2] == ($past(result_o) == '0));

    p_logic_keep_c_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_i >= 4'd2 && op_i <= 4'd5) |=> (flags_o[1] == $past(flags_o[1])) && !flags_o[0]);

    p_shift_zero_keep_c_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_i >= 4'd7 && op_i <= 4'd9 && b_i[AW-1:0] == '0) |=> flags_o[1] == $past(flags_o[1]));

endmodule

// File: tb/tb_nzcv_alu.sv
module tb_nzcv_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [15:0] a_i;
    logic [15:0] b_i;
    logic        flag_we;
    logic [15:0] result_o;
    logic        result_valid_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags;

    always #2 clk = ~clk;

    nzcv_alu dut (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .flag_we(flag_we), .result_o(result_o),
        .result_valid_o(result_valid_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference of one operation
    task automatic model(input int op, input int a, input int b, input logic [3:0] fin,
                         output int res, output bit vld, output bit legal, output logic [3:0] fo);
        int n;
        int s;
        logic signed [15:0] sa;
        bit c;
        bit v;
        c = fin[1]; v = fin[0]; legal = 1; vld = 1; res = 0;
        n = b & 15;
        sa = a[15:0];
        case (op)
            0: begin s = a + b; res = s & 16'hFFFF; c = s > 16'hFFFF;
                   v = (a[15] == b[15]) && (res[15] != a[15]); end
            1, 6: begin s = a + ((~b) & 16'hFFFF) + 1; res = s & 16'hFFFF; c = (a >= b);
                   v = (a[15] != b[15]) && (res[15] != a[15]); vld = (op == 1); end
            2: begin res = a & b; v = 0; end
            3: begin res = a | b; v = 0; end
            4: begin res = a ^ b; v = 0; end
            5: begin res = (~a) & 16'hFFFF; v = 0; end
            7: begin res = (a << n) & 16'hFFFF; if (n != 0) c = (a >> (16 - n)) & 1; v = 0; end
            8: begin res = a >> n; if (n != 0) c = (a >> (n - 1)) & 1; v = 0; end
            9: begin res = int'(sa >>> n) & 16'hFFFF; if (n != 0) c = (a >> (n - 1)) & 1; v = 0; end
            default: begin legal = 0; vld = 0; end
        endcase
        fo = legal ? {res[15], res == 0, c, v} : fin;
    endtask

    task automatic step(input string req, input int op, input int a, input int b, input bit we);
        int res; bit vld; bit legal; logic [3:0] fo;
        @(negedge clk);
        op_i = op[3:0]; a_i = a[15:0]; b_i = b[15:0]; flag_we = we;
        #1;
        model(op, a, b, mflags, res, vld, legal, fo);
        check({req, " result"}, result_o, res);
        check({req, " valid"}, result_valid_o, vld);
        check({req, " flags before edge"}, flags_o, mflags);
        @(posedge clk); #1;
        if (we && legal) mflags = fo;
        check({req, " flags after edge"}, flags_o, mflags);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; op_i = 0; a_i = 0; b_i = 0; flag_we = 0;
        mflags = 4'b0000;
        repeat (3) @(posedge clk);
        #1 check("R9 reset", flags_o, 0);
        @(negedge clk); rst = 0;

        step("R1 add plain", 0, 16'h0003, 16'h0004, 1);
        step("R1 add carry zero", 0, 16'hFFFF, 16'h0001, 1);
        step("R1 add signed ovf", 0, 16'h7FFF, 16'h0001, 1);
        step("R1 add neg ovf", 0, 16'h8000, 16'h8000, 1);
        step("R2 sub no borrow", 1, 16'h0010, 16'h0003, 1);
        step("R2 sub borrow", 1, 16'h0003, 16'h0010, 1);
        step("R2 sub ovf", 1, 16'h8000, 16'h0001, 1);
        step("R2 sub equal", 1, 16'h1234, 16'h1234, 1);
        step("R3 cmp", 6, 16'h0002, 16'h0005, 1);
        step("R3 cmp equal", 6, 16'h00AA, 16'h00AA, 1);
        step("R4 and keeps C", 2, 16'hF0F0, 16'h0FF0, 1);
        step("R4 or", 3, 16'h1200, 16'h0034, 1);
        step("R4 xor zero", 4, 16'h5A5A, 16'h5A5A, 1);
        step("R4 not", 5, 16'h00FF, 16'h0000, 1);
        step("R6 lsl", 7, 16'h8001, 16'h0001, 1);
        step("R6 lsl by 15", 7, 16'h0003, 16'h000F, 1);
        step("R6 lsr", 8, 16'h0003, 16'h0001, 1);
        step("R6 lsr far", 8, 16'h8000, 16'h000F, 1);
        step("R6 asr", 9, 16'h8004, 16'h0003, 1);
        step("R6 asr carry", 9, 16'hC002, 16'h0002, 1);
        step("R1 set C for R7", 0, 16'hFFFF, 16'h0002, 1);
        step("R7 lsl zero", 7, 16'h1234, 16'h0010, 1);
        step("R2 clear C for R7", 1, 16'h0000, 16'h0001, 1);
        step("R2 clear C for R7b", 1, 16'h0001, 16'h0002, 1);
        step("R7 asr zero", 9, 16'h8000, 16'h0000, 1);
        step("R8 sp add held", 0, 16'hFFFF, 16'h0001, 0);
        step("R8 sp sub held", 1, 16'h0000, 16'h0004, 0);
        step("R8 shift held", 7, 16'h8000, 16'h0001, 0);
        step("R10 illegal we", 12, 16'h1111, 16'h2222, 1);
        step("R10 illegal 15", 15, 16'h0000, 16'h0000, 1);
        step("R5 neg result", 0, 16'h8000, 16'h0001, 1);
        for (int i = 0; i < 40; i++) begin
            int op = i % 10;
            step("R5 sweep", op, (i * 16'h3B57) & 16'hFFFF, (i * 16'h1C3) & 16'hFFFF, (i % 3) != 0);
        end
        @(negedge clk); rst = 1;
        @(posedge clk); #1 check("R9 reset mid-run", flags_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule